// File: doc/BRIEF.md
# Memory-Mapped Handshake I/O Port

This peripheral hangs off a simple 16-bit processor bus. It offers one receive channel and one transmit channel. Each channel is driven by a three-step protocol: set up, wait, finish.

On the receive side, a word that arrives from the outside world is captured into a read-only data register, and a ready flag goes high. Software polls that flag, or takes an interrupt, then reads the word and clears the flag to re-arm the channel. A word that arrives while the flag is still high is discarded and recorded as an overrun. The interrupt request follows the ready flag, gated by an enable bit. Clearing the ready flag is the acknowledgement that lets the next request through.

On the transmit side, software loads a data register and sets a start bit. The device then models a slow transfer of programmable length. At the end it presents the word on its output with a one-cycle valid pulse and raises a done bit. Writing a zero start bit returns the channel to idle. This also aborts a transfer that is still running.

Top module: `mmio_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `irq`, `out_valid` and `bus_rdata` are 0, and every register reads back as 0.
- R2: When `in_valid` is high and the receive ready flag (status word at 0xFF02, bit 0) is clear, `in_data` is stored in the receive data word (0xFF00), and the ready flag is set on the same clock edge.
- R3: When `in_valid` is high and the ready flag is already set, the receive data word is unchanged and the overrun flag (0xFF02, bit 1) is set.
- R4: A write to 0xFF02 clears the ready flag where bit 0 of the written value is 0, and clears the overrun flag where bit 1 is 0. Writing ones never sets either flag. An arrival in the same cycle as a clearing write is judged against the flags as they stood before that write.
- R5: Writing 0xFF04 with bit 0 = 1 while the transmit channel is idle starts a transfer. The control word at 0xFF04 then reads 0x0001 (bit 0 = start, bit 1 = done), and the transmit data word (0xFF08) is captured for sending.
- R6: Exactly LATENCY cycles after the starting write's clock edge, `out_valid` pulses high for one cycle with the captured word on `out_data`, and the control word reads 0x0003 from then on.
- R7: Writing 0xFF04 with bit 0 = 0 returns the channel to idle, so the control word reads 0x0000. If a transfer is running, it is aborted and no `out_valid` pulse follows.
- R8: Writing 0xFF04 with bit 0 = 1 while a transfer is running or done has no effect: neither the timing nor the state changes.
- R9: `irq` equals (ready flag AND interrupt-enable bit, 0xFF06 bit 0) as it was one cycle earlier, so a new request can only follow a clear of the ready flag.
- R10: Register map: 0xFF00 receive data (read-only), 0xFF02 receive status, 0xFF04 transmit control, 0xFF06 interrupt enable (bit 0 only, other bits read 0), 0xFF08 transmit data (read/write), 0xFF0A reads 0. A read returns its data on `bus_rdata` after one clock edge, and `bus_rdata` holds that value until the next read. Odd or out-of-window addresses read 0 and ignore writes.
- R11: Writing the transmit data word during a transfer does not change the word that transfer delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Single-cycle bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| in_valid | input | 1 | Incoming word present this cycle |
| in_data | input | 16 | Incoming word |
| irq | output | 1 | Receive interrupt request |
| out_valid | output | 1 | One-cycle pulse: transmitted word present |
| out_data | output | 16 | Transmitted word |

## Verification
The bench targets the cycles where two things meet. It sends an arrival in the same cycle as a clearing write; a design that gave the clear priority would accept the word instead of flagging an overrun. It repeats the start command during a transfer; a design that restarted the counter would deliver late. It rewrites the transmit data mid-transfer; a design that sent the live register would deliver the wrong word. It also checks that an aborted transfer never pulses `out_valid`, that `irq` lags the ready flag by exactly one cycle and drops after the acknowledgement, and that the done pulse arrives exactly LATENCY cycles after the start.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int NUM_REGS = 6;

  typedef enum logic [2:0] {
    SEL_RXDATA = 3'd0,
    SEL_RXSTAT = 3'd1,
    SEL_TXCTRL = 3'd2,
    SEL_IRQEN  = 3'd3,
    SEL_TXDATA = 3'd4,
    SEL_SPARE  = 3'd5,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BUSY = 2'd1,
    TX_DONE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int AW   = 16,
  parameter int BASE = 'hFF00
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] SPAN   = AW'(2 * NUM_REGS);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - BASE_A;
    if (addr >= BASE_A && off < SPAN && !addr[0])
      sel = reg_sel_e'(off[3:1]);
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/mmio_rx_chan.sv
module mmio_rx_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          stat_wr,
  input  logic [1:0]    stat_keep,
  input  logic          en_wr,
  input  logic          en_val,
  output logic [DW-1:0] data_q,
  output logic          rdy_q,
  output logic          ovr_q,
  output logic          ie_q,
  output logic          irq_q
);
  logic clr_rdy, clr_ovr;

  assign clr_rdy = stat_wr & ~stat_keep[0];
  assign clr_ovr = stat_wr & ~stat_keep[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (in_valid && !rdy_q)
        data_q <= in_data;
      rdy_q <= (rdy_q & ~clr_rdy) | (in_valid & ~rdy_q);
      ovr_q <= (ovr_q & ~clr_ovr) | (in_valid & rdy_q);
      if (en_wr)
        ie_q <= en_val;
      irq_q <= rdy_q & ie_q;
    end
  end
endmodule

// File: rtl/mmio_tx_chan.sv
module mmio_tx_chan
  import mmio_pkg::*;
#(
  parameter int DW      = 16,
  parameter int LATENCY = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_wr,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] txd_q,
  output logic          start_o,
  output logic          done_o,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      cnt       <= '0;
      txd_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (data_wr)
        txd_q <= wdata;
      if (ctrl_wr && !wdata[0]) begin
        st <= TX_IDLE;
      end else if (ctrl_wr && st == TX_IDLE) begin
        st       <= TX_BUSY;
        cnt      <= CNT_LOAD;
        out_data <= txd_q;
      end else if (st == TX_BUSY) begin
        if (cnt == '0) begin
          st        <= TX_DONE;
          out_valid <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign start_o = (st != TX_IDLE);
  assign done_o  = (st == TX_DONE);
endmodule

// File: rtl/mmio_port.sv
module mmio_port
  import mmio_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int BASE    = 'hFF00,
  parameter int LATENCY = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          irq,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  reg_sel_e      sel;
  logic          wr, rd;
  logic          wr_stat, wr_en, wr_ctrl, wr_txd;
  logic [DW-1:0] rxd_q, txd_q;
  logic          rdy_q, ovr_q, ie_q, tx_start, tx_done;

  mmio_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_stat = wr && sel == SEL_RXSTAT;
  assign wr_en   = wr && sel == SEL_IRQEN;
  assign wr_ctrl = wr && sel == SEL_TXCTRL;
  assign wr_txd  = wr && sel == SEL_TXDATA;

  mmio_rx_chan #(.DW(DW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .stat_wr   (wr_stat),
    .stat_keep (bus_wdata[1:0]),
    .en_wr     (wr_en),
    .en_val    (bus_wdata[0]),
    .data_q    (rxd_q),
    .rdy_q     (rdy_q),
    .ovr_q     (ovr_q),
    .ie_q      (ie_q),
    .irq_q     (irq)
  );

  mmio_tx_chan #(.DW(DW), .LATENCY(LATENCY)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .data_wr   (wr_txd),
    .ctrl_wr   (wr_ctrl),
    .wdata     (bus_wdata),
    .txd_q     (txd_q),
    .start_o   (tx_start),
    .done_o    (tx_done),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (sel)
        SEL_RXDATA: bus_rdata <= rxd_q;
        SEL_RXSTAT: bus_rdata <= {{(DW-2){1'b0}}, ovr_q, rdy_q};
        SEL_TXCTRL: bus_rdata <= {{(DW-2){1'b0}}, tx_done, tx_start};
        SEL_IRQEN:  bus_rdata <= {{(DW-1){1'b0}}, ie_q};
        SEL_TXDATA: bus_rdata <= txd_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_port_chk.sv
module mmio_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic [DW-1:0] rxd,
  input logic          rdy,
  input logic          ovr,
  input logic          ie,
  input logic          irq,
  input logic          start_bit,
  input logic          done_bit,
  input logic          out_valid,
  input logic          ctrl_wr,
  input logic          ctrl_bit0,
  input logic [DW-1:0] bus_rdata
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!irq && !out_valid && !rdy && !start_bit && bus_rdata == '0)); // R1

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rdy) |=> (rdy && rxd == $past(in_data))); // R2

  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rdy) |=> ($stable(rxd) && ovr)); // R3

  AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_bit) |-> out_valid); // R6

  AST_TX_ABORT: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ctrl_bit0) |=> (!start_bit && !done_bit && !out_valid)); // R7

  AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start_bit && !(ctrl_wr && !ctrl_bit0)) |=> start_bit); // R8

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rdy && ie)); // R9
endmodule

bind mmio_port mmio_port_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .rxd       (rxd_q),
  .rdy       (rdy_q),
  .ovr       (ovr_q),
  .ie        (ie_q),
  .irq       (irq),
  .start_bit (tx_start),
  .done_bit  (tx_done),
  .out_valid (out_valid),
  .ctrl_wr   (wr_ctrl),
  .ctrl_bit0 (bus_wdata[0]),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_mmio_port.sv
`timescale 1ns/1ps
module sim_mmio_port;
  localparam int LAT = 6;
  localparam logic [15:0] A_RXD = 16'hFF00, A_STAT = 16'hFF02, A_CTRL = 16'hFF04;
  localparam logic [15:0] A_IEN = 16'hFF06, A_TXD = 16'hFF08, A_SPR = 16'hFF0A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, in_data = '0;
  logic in_valid = 1'b0;
  logic [15:0] bus_rdata, out_data;
  logic irq, out_valid;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mmio_port #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_valid(in_valid), .in_data(in_data), .irq(irq),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rxd, m_rdy, m_ovr, m_ie, m_txd, m_st, m_cnt, m_od, m_ov, m_irq, m_rdata;

  always @(posedge clk) begin
    int o_rdy, o_ovr, o_ie, o_txd, o_st;
    if (rst) begin
      m_rxd = 0; m_rdy = 0; m_ovr = 0; m_ie = 0; m_txd = 0;
      m_st = 0; m_cnt = 0; m_od = 0; m_ov = 0; m_irq = 0; m_rdata = 0;
    end else begin
      o_rdy = m_rdy; o_ovr = m_ovr; o_ie = m_ie; o_txd = m_txd; o_st = m_st;
      if (bus_sel && !bus_we) begin
        if (bus_addr == A_RXD) m_rdata = m_rxd;
        else if (bus_addr == A_STAT) m_rdata = o_ovr * 2 + o_rdy;
        else if (bus_addr == A_CTRL) m_rdata = (o_st == 2) ? 3 : (o_st == 1) ? 1 : 0;
        else if (bus_addr == A_IEN) m_rdata = o_ie;
        else if (bus_addr == A_TXD) m_rdata = o_txd;
        else m_rdata = 0;
      end
      m_irq = o_rdy & o_ie;
      m_ov = 0;
      if (bus_sel && bus_we && bus_addr == A_STAT) begin
        if (!bus_wdata[0]) m_rdy = 0;
        if (!bus_wdata[1]) m_ovr = 0;
      end
      if (in_valid) begin
        if (o_rdy) m_ovr = 1;
        else begin m_rdy = 1; m_rxd = in_data; end
      end
      if (bus_sel && bus_we && bus_addr == A_IEN) m_ie = bus_wdata[0];
      if (bus_sel && bus_we && bus_addr == A_TXD) m_txd = bus_wdata;
      if (bus_sel && bus_we && bus_addr == A_CTRL && !bus_wdata[0]) m_st = 0;
      else if (bus_sel && bus_we && bus_addr == A_CTRL && o_st == 0) begin
        m_st = 1; m_cnt = LAT; m_od = o_txd;
      end else if (o_st == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_st = 2; m_ov = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R9 irq vs model", irq, m_irq);
      check("R6 out_valid vs model", out_valid, m_ov);
      check("R10 rdata vs model", bus_rdata, m_rdata);
      if (out_valid) check("R11 out_data vs model", out_data, m_od);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input int exp, input string tag);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic push(input logic [15:0] d);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    int seen;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 0);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 rdata in reset", bus_rdata, 0);
    rst = 0;
    rd(A_STAT, 0, "R1 status after reset");
    rd(A_CTRL, 0, "R1 control after reset");
    rd(A_RXD, 0, "R1 rx data after reset");

    push(16'hA5A5);
    rd(A_STAT, 1, "R2 ready set");
    rd(A_RXD, 16'hA5A5, "R2 data captured");
    push(16'h1234);
    rd(A_RXD, 16'hA5A5, "R3 data kept on overrun");
    rd(A_STAT, 3, "R3 overrun flag");

    wr(A_STAT, 16'h0003);
    rd(A_STAT, 3, "R4 ones do not clear");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 0, "R4 cleared");
    push(16'h1111);
    bus_sel = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 16'h0000;
    in_valid = 1; in_data = 16'h2222;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; in_valid = 0;
    rd(A_STAT, 2, "R4 same-cycle clear and arrival");
    rd(A_RXD, 16'h1111, "R4 same-cycle word dropped");
    wr(A_STAT, 16'h0000);

    wr(A_IEN, 16'hFFFF);
    rd(A_IEN, 1, "R10 enable reads bit 0 only");
    push(16'h0042);
    check("R9 irq lags ready", irq, 0);
    idle(1);
    check("R9 irq raised", irq, 1);
    wr(A_STAT, 16'h0000);
    check("R9 irq held one cycle after clear", irq, 1);
    idle(1);
    check("R9 irq dropped after ack", irq, 0);
    push(16'h0077);
    idle(1);
    check("R9 new request after ack", irq, 1);
    wr(A_IEN, 16'h0000);
    idle(1);
    check("R9 irq masked", irq, 0);
    wr(A_STAT, 16'h0000);

    wr(A_RXD, 16'hFFFF);
    rd(A_RXD, 16'h0077, "R10 rx data read-only");
    rd(A_SPR, 0, "R10 spare reads zero");
    wr(16'hFF09, 16'hBEEF);
    wr(16'hFF0C, 16'hBEEF);
    rd(A_TXD, 0, "R10 odd/outside writes ignored");
    rd(16'hFF0C, 0, "R10 outside reads zero");
    wr(A_TXD, 16'h5A5A);
    rd(A_TXD, 16'h5A5A, "R10 tx data readback");

    wr(A_TXD, 16'hC0DE);
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, 1, "R5 busy reads start");
    wr(A_TXD, 16'h0BAD);
    k = 2;
    while (!out_valid && k < LAT + 5) begin @(negedge clk); k++; end
    check("R6 latency", k, LAT);
    check("R11 delivered word", out_data, 16'hC0DE);
    rd(A_CTRL, 3, "R6 done bit");
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, 3, "R8 start while done ignored");
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, 0, "R7 clear returns idle");

    wr(A_CTRL, 16'h0001);
    wr(A_CTRL, 16'h0001);
    k = 1;
    while (!out_valid && k < LAT + 5) begin @(negedge clk); k++; end
    check("R8 start while busy keeps timing", k, LAT);
    check("R5 captured word", out_data, 16'h0BAD);
    wr(A_CTRL, 16'h0000);

    wr(A_CTRL, 16'h0001);
    idle(2);
    wr(A_CTRL, 16'h0000);
    seen = 0;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    check("R7 abort suppresses out_valid", seen, 0);
    rd(A_CTRL, 0, "R7 abort reads idle");

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule